// File: doc/BRIEF.md
# Slave Cycle Bus Arbitration Sequencer

This block decides how a bus slave services an incoming data cycle when its internal address and data buses are shared with another master. At the start of each data cycle it samples two synchronised lines: an active-low enable (`en_ni`) and a busy flag (`busy_i`). From these it picks one of three paths. It can run the cycle directly. It can complete the cycle at once without touching the shared buses. Or it can raise a bus request and hold the initiator off with a wait signal until the other master grants the buses.

A grant is recognised only after the enable line has been seen low for `GRANT_CYCLES` consecutive clocks. The count is chosen so that it covers the required minimum low time. After a granted transfer finishes, the block releases its signals in a fixed order. The request drops first. The wait signal is released one clock later. The not-running indicator is released one clock after that, when the buses are free. Address cycles are also answered here. Primary address cycles are always acknowledged. For logical address cycles, the address comparison is skipped while the slave is not enabled.

Top module: `slave_arb_seq`

## Requirements
- R1: After reset, `req_o`=0, `wait_o`=0, `nrun_no`=1, `xfer_no`=1, `stat_vld_o`=0 and `addr_ack_o`=0.
- R2: A primary address cycle (`addr_cyc_i`=1, `addr_primary_i`=1) gives `addr_ack_o`=1 in the next cycle, whatever `en_ni` and `addr_match_i` are.
- R3: A logical address cycle (`addr_primary_i`=0) while the synchronised `en_ni` is high gives no acknowledge, even if `addr_match_i`=1. It gives `stat_vld_o`=1 with `stat_o`=0 in the next cycle. While `en_ni` is low, it is acknowledged in the next cycle exactly when `addr_match_i`=1.
- R4: A data cycle that starts with `en_ni` low runs directly. From the next cycle `xfer_no` is 0 and `req_o`, `wait_o` are 0, until `cyc_end_i`. Raising `en_ni` during the cycle does not end it. After `cyc_end_i`, `xfer_no` returns to 1 and `stat_vld_o`=1 with `stat_o`=0 for one cycle.
- R5: A data cycle that starts with `en_ni` high and `busy_i` high completes at once. In the next cycle `stat_vld_o`=1 with `stat_o`=1. `xfer_no` stays 1 and `req_o` stays 0.
- R6: A data cycle that starts with `en_ni` high and `busy_i` low raises `req_o` and `wait_o` in the next cycle. `nrun_no` stays 1 and `xfer_no` stays 1 until a grant.
- R7: `en_ni` and `busy_i` pass through two flops. A grant needs `GRANT_CYCLES` consecutive low samples of the synchronised enable. `nrun_no` and `xfer_no` fall exactly `GRANT_CYCLES`+3 clock edges after `en_ni` is first driven low. A low pulse seen for fewer samples grants nothing, and the count restarts.
- R8: In a granted transfer, the `cyc_end_i` edge causes the following sequence:
  - In the next cycle, `req_o`=0, `wait_o`=1, `nrun_no`=0, `xfer_no`=1, and `stat_vld_o`=1 with `stat_o`=0.
  - One cycle later, `wait_o`=0 and `nrun_no`=0.
  - One cycle after that, `nrun_no`=1.
- R9: `cyc_start_i` is ignored while a data cycle is in progress. A start pulse during a pending request leaves `req_o`/`wait_o` high and produces no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Input enable / grant from the other master, active low, asynchronous |
| busy_i | input | 1 | Slave busy, asynchronous |
| cyc_start_i | input | 1 | One-cycle pulse: a data cycle begins |
| cyc_end_i | input | 1 | One-cycle pulse: the data cycle has finished |
| addr_cyc_i | input | 1 | One-cycle pulse: an address cycle |
| addr_primary_i | input | 1 | 1 = primary address cycle, 0 = logical |
| addr_match_i | input | 1 | Result of the address-field comparison |
| req_o | output | 1 | Bus request to the other master |
| wait_o | output | 1 | Hold-off to the cycle initiator |
| nrun_no | output | 1 | Not-running, low while this slave owns the internal buses |
| xfer_no | output | 1 | Data-transfer strobe, active low |
| stat_o | output | 1 | Status code: 0 = done, 1 = skipped because busy |
| stat_vld_o | output | 1 | One-cycle strobe qualifying `stat_o` |
| addr_ack_o | output | 1 | One-cycle address acknowledge |

## Verification
The hardest situation to reach is the grant boundary. The enable line has to reach the filter through two flops and then stay low for exactly the right number of samples. The stimulus first holds a pending request and pulses `en_ni` low for one sample too few, then checks that nothing is granted over several cycles. It then drives `en_ni` low for good and checks `nrun_no` on both sides of the exact edge where the grant must land. The release sequence is then walked cycle by cycle from the `cyc_end_i` pulse.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DIRECT, ST_REQ, ST_XFER, ST_RELEASE, ST_FREE
  } arb_state_e;

  localparam logic STAT_DONE = 1'b0;
  localparam logic STAT_SKIP = 1'b1;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int unsigned          WIDTH   = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/grant_filter.sv
module grant_filter #(
  parameter int unsigned GRANT_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_low_i,
  output logic granted_o
);
  localparam int unsigned CW = $clog2(GRANT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(GRANT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || !en_low_i)     cnt_q <= '0;
    else if (cnt_q != CNT_MAX)       cnt_q <= cnt_q + 1'b1;
  end

  assign granted_o = (cnt_q == CNT_MAX);

  // a grant needs an unbroken run of low samples
  assert_grant_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_low_i && !clr_i) |=> !granted_o);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import slv_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_n_s_i,
  input  logic busy_s_i,
  input  logic granted_i,
  input  logic cyc_start_i,
  input  logic cyc_end_i,
  input  logic addr_cyc_i,
  input  logic addr_primary_i,
  input  logic addr_match_i,
  output logic req_o,
  output logic wait_o,
  output logic nrun_no,
  output logic xfer_no,
  output logic stat_o,
  output logic stat_vld_o,
  output logic addr_ack_o,
  output logic start_acc_o
);
  arb_state_e state_q, state_d;
  logic       stat_q, stat_vld_q, ack_q;
  logic       bypass, data_done;

  assign start_acc_o = (state_q == ST_IDLE) && cyc_start_i;
  assign bypass      = start_acc_o && en_n_s_i && busy_s_i;
  assign data_done   = cyc_end_i && ((state_q == ST_DIRECT) || (state_q == ST_XFER));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (cyc_start_i) begin
          if (!en_n_s_i)      state_d = ST_DIRECT;
          else if (!busy_s_i) state_d = ST_REQ;
        end
      ST_DIRECT:  if (cyc_end_i) state_d = ST_IDLE;
      ST_REQ:     if (granted_i) state_d = ST_XFER;
      ST_XFER:    if (cyc_end_i) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_FREE;
      ST_FREE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= STAT_DONE;
      stat_vld_q <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      stat_vld_q <= 1'b0;
      if (bypass) begin
        stat_vld_q <= 1'b1;
        stat_q     <= STAT_SKIP;
      end else if (data_done) begin
        stat_vld_q <= 1'b1;
        stat_q     <= STAT_DONE;
      end else if (addr_cyc_i && !addr_primary_i && en_n_s_i) begin
        stat_vld_q <= 1'b1;
        stat_q     <= STAT_DONE;
      end
      ack_q <= addr_cyc_i && (addr_primary_i || (!en_n_s_i && addr_match_i));
    end
  end

  assign req_o      = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign wait_o     = req_o || (state_q == ST_RELEASE);
  assign nrun_no    = !((state_q == ST_XFER) || (state_q == ST_RELEASE) || (state_q == ST_FREE));
  assign xfer_no    = !((state_q == ST_DIRECT) || (state_q == ST_XFER));
  assign stat_o     = stat_q;
  assign stat_vld_o = stat_vld_q;
  assign addr_ack_o = ack_q;

  assert_primary_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_cyc_i && addr_primary_i) |=> addr_ack_o);
  assert_direct_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_no && req_o == 1'b0 && !cyc_end_i) |=> !xfer_no);
  assert_bypass_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> (stat_vld_o && stat_o && xfer_no && !req_o));
  assert_req_with_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> wait_o);
  assert_run_after_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nrun_no) |-> $past(granted_i));
  assert_req_drop_keeps_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> (!nrun_no && wait_o));
  assert_wait_before_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nrun_no) |-> $past(!wait_o));
endmodule

// File: rtl/slave_arb_seq.sv
module slave_arb_seq #(
  parameter int unsigned GRANT_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  input  logic busy_i,
  input  logic cyc_start_i,
  input  logic cyc_end_i,
  input  logic addr_cyc_i,
  input  logic addr_primary_i,
  input  logic addr_match_i,
  output logic req_o,
  output logic wait_o,
  output logic nrun_no,
  output logic xfer_no,
  output logic stat_o,
  output logic stat_vld_o,
  output logic addr_ack_o
);
  logic [1:0] sync_q;
  logic       en_n_s, busy_s, granted, start_acc;

  sync2 #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({busy_i, en_ni}),
    .q_o   (sync_q)
  );
  assign en_n_s = sync_q[0];
  assign busy_s = sync_q[1];

  grant_filter #(.GRANT_CYCLES(GRANT_CYCLES)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_acc),
    .en_low_i (!en_n_s),
    .granted_o(granted)
  );

  arb_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_n_s_i      (en_n_s),
    .busy_s_i      (busy_s),
    .granted_i     (granted),
    .cyc_start_i   (cyc_start_i),
    .cyc_end_i     (cyc_end_i),
    .addr_cyc_i    (addr_cyc_i),
    .addr_primary_i(addr_primary_i),
    .addr_match_i  (addr_match_i),
    .req_o         (req_o),
    .wait_o        (wait_o),
    .nrun_no       (nrun_no),
    .xfer_no       (xfer_no),
    .stat_o        (stat_o),
    .stat_vld_o    (stat_vld_o),
    .addr_ack_o    (addr_ack_o),
    .start_acc_o   (start_acc)
  );
endmodule

// File: tb/slave_arb_seq_test.sv
module slave_arb_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_n = 1'b1, busy = 1'b0, start = 1'b0, cend = 1'b0;
  logic acyc = 1'b0, aprim = 1'b0, amatch = 1'b0;
  logic req, wt, nrun_n, xfer_n, stat, stat_vld, ack;
  int   n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slave_arb_seq #(.GRANT_CYCLES(G)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .busy_i(busy),
    .cyc_start_i(start), .cyc_end_i(cend), .addr_cyc_i(acyc),
    .addr_primary_i(aprim), .addr_match_i(amatch),
    .req_o(req), .wait_o(wt), .nrun_no(nrun_n), .xfer_no(xfer_n),
    .stat_o(stat), .stat_vld_o(stat_vld), .addr_ack_o(ack)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int k = 1);
    repeat (k) @(negedge clk);
  endtask

  task automatic settle(input logic e, input logic b);
    en_n = e; busy = b; step(3);
  endtask

  task automatic pulse_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic pulse_end();
    cend = 1'b1; step(); cend = 1'b0;
  endtask

  task automatic addr_cycle(input logic p, input logic m);
    acyc = 1'b1; aprim = p; amatch = m; step(); acyc = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req", req, 1'b0);       chk("R1 wait", wt, 1'b0);
    chk("R1 nrun_n", nrun_n, 1'b1); chk("R1 xfer_n", xfer_n, 1'b1);
    chk("R1 stat_vld", stat_vld, 1'b0); chk("R1 ack", ack, 1'b0);
  endtask

  task automatic t_primary();
    settle(1'b1, 1'b0);
    addr_cycle(1'b1, 1'b0); chk("R2 ack en high", ack, 1'b1);
    step(); chk("R2 ack one cycle", ack, 1'b0);
    settle(1'b0, 1'b0);
    addr_cycle(1'b1, 1'b0); chk("R2 ack en low", ack, 1'b1);
  endtask

  task automatic t_logical();
    settle(1'b1, 1'b0);
    addr_cycle(1'b0, 1'b1);
    chk("R3 no ack disabled", ack, 1'b0);
    chk("R3 stat_vld", stat_vld, 1'b1); chk("R3 stat 0", stat, 1'b0);
    settle(1'b0, 1'b0);
    addr_cycle(1'b0, 1'b1);
    chk("R3 ack on match", ack, 1'b1); chk("R3 no stat", stat_vld, 1'b0);
    addr_cycle(1'b0, 1'b0);
    chk("R3 no ack on miss", ack, 1'b0);
  endtask

  task automatic t_direct();
    settle(1'b0, 1'b1);
    pulse_start();
    chk("R4 xfer low", xfer_n, 1'b0); chk("R4 no req", req, 1'b0);
    chk("R4 no wait", wt, 1'b0);      chk("R4 nrun high", nrun_n, 1'b1);
    en_n = 1'b1; step(5);
    chk("R4 no abort", xfer_n, 1'b0);
    pulse_end();
    chk("R4 xfer released", xfer_n, 1'b1);
    chk("R4 stat_vld", stat_vld, 1'b1); chk("R4 stat 0", stat, 1'b0);
    step(); chk("R4 stat one cycle", stat_vld, 1'b0);
  endtask

  task automatic t_bypass();
    settle(1'b1, 1'b1);
    pulse_start();
    chk("R5 stat_vld", stat_vld, 1'b1); chk("R5 stat 1", stat, 1'b1);
    chk("R5 xfer idle", xfer_n, 1'b1);  chk("R5 no req", req, 1'b0);
    step(); chk("R5 stat one cycle", stat_vld, 1'b0);
    chk("R5 still idle", xfer_n, 1'b1);
  endtask

  task automatic t_arbitrated();
    settle(1'b1, 1'b0);
    pulse_start();
    chk("R6 req", req, 1'b1); chk("R6 wait", wt, 1'b1);
    chk("R6 nrun high", nrun_n, 1'b1); chk("R6 xfer idle", xfer_n, 1'b1);
    pulse_start();
    chk("R9 req kept", req, 1'b1); chk("R9 no stat", stat_vld, 1'b0);
    // short grant pulse, one sample too few
    en_n = 1'b0; step(G - 1); en_n = 1'b1;
    for (int i = 0; i < G + 3; i++) begin
      step(); chk("R7 short pulse no grant", nrun_n, 1'b1);
    end
    en_n = 1'b0; step(G + 2);
    chk("R7 not yet granted", nrun_n, 1'b1);
    step();
    chk("R7 granted nrun", nrun_n, 1'b0); chk("R7 granted xfer", xfer_n, 1'b0);
    chk("R7 req held", req, 1'b1);
    step(2); chk("R8 xfer held", xfer_n, 1'b0);
    pulse_end();
    chk("R8 req dropped", req, 1'b0);    chk("R8 wait held", wt, 1'b1);
    chk("R8 nrun held", nrun_n, 1'b0);   chk("R8 xfer released", xfer_n, 1'b1);
    chk("R8 stat_vld", stat_vld, 1'b1);  chk("R8 stat 0", stat, 1'b0);
    step();
    chk("R8 wait released", wt, 1'b0);   chk("R8 nrun still low", nrun_n, 1'b0);
    step();
    chk("R8 nrun released", nrun_n, 1'b1);
  endtask

  initial begin
    step(2); t_reset();
    rst_n = 1'b1; step();
    t_reset();
    t_primary();
    t_logical();
    t_direct();
    t_bypass();
    t_arbitrated();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule